// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block finds the divider settings for a clock synthesizer. It takes a requested output frequency and the reference frequency, both in kHz. It then walks through every candidate post-divider index (PL), input divider (M) and feedback divider (N). It keeps the combination whose output lands nearest to twice the requested rate. Frequency limits on the oscillator and on the comparison stage prune the search, and the search stops as soon as an exact match is found.

Software or a power-management sequencer applies the two frequencies and pulses `start`. While it waits, one shared serial divider performs every quotient the search needs, so the run time depends on how quickly the search converges. When the engine finishes it pulses `done` for one cycle. The chosen M, N and PL, together with the residual error, then stay on the outputs until the next search begins. If no candidate qualifies, the engine raises a no-match indication and reports fixed fallback values.

Top module: `pll_coef_search`

## Requirements
- R1: After reset `done` is low, the result outputs show M=255, N=8, PL=1, and `noMatch` is high.
- R2: Post-divider index k (0..14) selects divide ratio 1,2,3,4,5,6,8,10,12,16,12,16,20,24,32 respectively; any other index reads as divide-by-1.
- R3: With T = 2·target and V = T + floor(T/50), the oscillator ceiling is max(2,064,000, V) and the floor is 1,000,000. PL runs from index(floor(1,000,000/V)) to index(ceil(ceiling/V)). Each ratio is clamped to 1..32 before conversion, and index(r) is the first index whose ratio is at least r, or 14 if none is.
- R4: For each PL, M runs upward from 1 with comparison frequency ref/M. A value below 12,000 ends the M sweep for that PL, a value above 38,000 skips that M, and the sweep also ends after M=255.
- R5: With W = T·ratio(PL)·M, N runs from floor(W/ref) to ceil(W/ref). If the floor exceeds 255 the M sweep ends, N below 8 is skipped, and N above 255 ends the N sweep.
- R6: A candidate is valid only when floor(ref·N/M) lies in [floor, ceiling]. Its error is |floor((vco + floor(ratio/2))/ratio) − T|.
- R7: A valid candidate replaces the kept one only when its error is strictly smaller, and an error of zero ends the search at once.
- R8: If no candidate is valid, the result is M=255, N=8, PL=1 with the error all ones and `noMatch` high. Otherwise `noMatch` is low.
- R9: `done` is high for exactly one cycle per search, and the results then hold until the next accepted `start`.
- R10: A `start` pulse that arrives while a search is in progress is ignored. The running search completes with its own inputs and produces exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; inputs are sampled on this cycle |
| targetKhz | input | 24 | Requested output frequency in kHz, nonzero |
| refKhz | input | 24 | Reference frequency in kHz, nonzero |
| done | output | 1 | One-cycle pulse when the result is final |
| bestM | output | 8 | Selected input divider |
| bestN | output | 8 | Selected feedback divider |
| bestPl | output | 4 | Selected post-divider index |
| bestErr | output | 40 | Residual error in kHz of the doubled target, all ones if none |
| noMatch | output | 1 | No valid candidate was found |

## Verification
Any corruption of a loop counter or a kept value shows up in the one `done` cycle as an M, N, PL or error that differs from a behavioural model of the search. An early or late exit shows up the same way. A bad exit condition shows up either as a wrong coefficient or as a missing `done`, which the bench catches within its cycle limit. The bench keeps a scoreboard that contains exact-match, inexact and three different no-match cases. It also checks that `done` is a single-cycle pulse, that an extra `start` produces no second result, and that the outputs hold afterwards.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  parameter int FreqW = 24;
  localparam int WideW = FreqW + 16;
  localparam int CoefW = 8;
  localparam int PlW = 4;
  localparam int PlCount = 15;
  localparam int MMax = 255;
  localparam int NMin = 8;
  localparam int NMax = 255;
  localparam int VcoMinKhz = 1000000;
  localparam int VcoMaxKhz = 2064000;
  localparam int CmpMinKhz = 12000;
  localparam int CmpMaxKhz = 38000;
  localparam int MarginDiv = 50;
  localparam int PostDivMin = 1;
  localparam int PostDivMax = 32;
  localparam int DefaultPl = 1;

  typedef enum logic [2:0] {OpVt, OpHi, OpLo, OpUf, OpN, OpVco, OpLwv} divOpE;

  typedef struct packed {
    logic  init;
    logic  divGo;
    divOpE divOp;
    logic  mFirst;
    logic  mInc;
    logic  nLoad;
    logic  nInc;
    logic  plInc;
    logic  take;
  } ctrlStbT;

  typedef struct packed {
    logic divDone;
    logic plOver;
    logic mLast;
    logic ufLow;
    logic ufHigh;
    logic nLoBig;
    logic nPast;
    logic nSmall;
    logic nBig;
    logic vcoOk;
    logic better;
    logic exact;
  } dpStatT;

  function automatic logic [5:0] plToDiv(input logic [PlW-1:0] idx);
    case (idx)
      4'd0:  return 6'd1;
      4'd1:  return 6'd2;
      4'd2:  return 6'd3;
      4'd3:  return 6'd4;
      4'd4:  return 6'd5;
      4'd5:  return 6'd6;
      4'd6:  return 6'd8;
      4'd7:  return 6'd10;
      4'd8:  return 6'd12;
      4'd9:  return 6'd16;
      4'd10: return 6'd12;
      4'd11: return 6'd16;
      4'd12: return 6'd20;
      4'd13: return 6'd24;
      4'd14: return 6'd32;
      default: return 6'd1;
    endcase
  endfunction

  function automatic logic [PlW-1:0] divToPl(input logic [WideW-1:0] ratio);
    logic [WideW-1:0] c;
    logic [PlW-1:0] res;
    logic hit;
    if (ratio < WideW'(PostDivMin)) c = WideW'(PostDivMin);
    else if (ratio > WideW'(PostDivMax)) c = WideW'(PostDivMax);
    else c = ratio;
    res = PlW'(PlCount - 1);
    hit = 1'b0;
    for (int i = 0; i < PlCount - 1; i++) begin
      if (!hit && WideW'(plToDiv(PlW'(i))) >= c) begin
        res = PlW'(i);
        hit = 1'b1;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/pll_search_div.sv
module pll_search_div #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CntW = $clog2(W + 1);

  logic [W-1:0]    acc, quo, dvs;
  logic [CntW-1:0] cnt;
  logic            busy;
  logic [W:0]      trial;

  assign trial = {acc, quo[W-1]};
  assign quot  = quo;
  assign rem   = acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0; quo <= '0; dvs <= '0; cnt <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        acc  <= '0;
        quo  <= dividend;
        dvs  <= divisor;
        cnt  <= CntW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        if (trial >= {1'b0, dvs}) begin
          acc <= W'(trial - {1'b0, dvs});
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          acc <= trial[W-1:0];
          quo <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt - CntW'(1);
        if (cnt == CntW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6: every quotient feeding the error math carries a proper remainder
  p_rem_below_divisor_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && dvs != '0) |-> (rem < dvs));
endmodule

// File: rtl/pll_search_dp.sv
module pll_search_dp
  import pll_search_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStbT          stb,
  input  logic [FreqW-1:0] targetKhz,
  input  logic [FreqW-1:0] refKhz,
  output dpStatT           stat,
  output logic [CoefW-1:0] bestM,
  output logic [CoefW-1:0] bestN,
  output logic [PlW-1:0]   bestPl,
  output logic [WideW-1:0] bestErr,
  output logic             noMatch
);
  logic [FreqW-1:0] tgtQ, refQ;
  logic [WideW-1:0] t2, vt, maxVco, uf, nLo, nCur, nHi, vco, lwv, delta, divC, wRef, wM;
  logic [WideW-1:0] dvd, dvs, quot, rem;
  logic [PlW-1:0]   pl, plHi;
  logic [8:0]       m;
  divOpE            opQ;
  logic             divDone;

  assign t2     = WideW'(tgtQ) << 1;
  assign maxVco = (vt > WideW'(VcoMaxKhz)) ? vt : WideW'(VcoMaxKhz);
  assign divC   = WideW'(plToDiv(pl));
  assign wRef   = WideW'(refQ);
  assign wM     = WideW'(m);
  assign delta  = (lwv >= t2) ? lwv - t2 : t2 - lwv;

  always_comb begin
    dvd = '0; dvs = WideW'(1);
    case (stb.divOp)
      OpVt:  begin dvd = t2;                        dvs = WideW'(MarginDiv); end
      OpHi:  begin dvd = maxVco + vt - WideW'(1);   dvs = vt;                end
      OpLo:  begin dvd = WideW'(VcoMinKhz);         dvs = vt;                end
      OpUf:  begin dvd = wRef;                      dvs = wM;                end
      OpN:   begin dvd = t2 * divC * wM;            dvs = wRef;              end
      OpVco: begin dvd = wRef * nCur;               dvs = wM;                end
      OpLwv: begin dvd = vco + (divC >> 1);         dvs = divC;              end
      default: ;
    endcase
  end

  pll_search_div #(.W(WideW)) u_div (
    .clk(clk), .rstN(rstN), .go(stb.divGo), .dividend(dvd), .divisor(dvs),
    .done(divDone), .quot(quot), .rem(rem)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtQ <= '0; refQ <= '0; vt <= '0; uf <= '0; nLo <= '0; nCur <= '0; nHi <= '0;
      vco <= '0; lwv <= '0; pl <= '0; plHi <= '0; m <= '0; opQ <= OpVt;
      bestM <= CoefW'(MMax); bestN <= CoefW'(NMin); bestPl <= PlW'(DefaultPl); bestErr <= '1;
    end else begin
      if (stb.init) begin
        tgtQ <= targetKhz; refQ <= refKhz;
        bestM <= CoefW'(MMax); bestN <= CoefW'(NMin); bestPl <= PlW'(DefaultPl); bestErr <= '1;
      end
      if (stb.divGo) opQ <= stb.divOp;
      if (divDone) begin
        case (opQ)
          OpVt:  vt   <= t2 + quot;
          OpHi:  plHi <= divToPl(quot);
          OpLo:  pl   <= divToPl(quot);
          OpUf:  uf   <= quot;
          OpN:   begin nLo <= quot; nHi <= quot + WideW'(rem != '0); end
          OpVco: vco  <= quot;
          OpLwv: lwv  <= quot;
          default: ;
        endcase
      end
      if (stb.mFirst) m <= 9'd1;
      if (stb.mInc)   m <= m + 9'd1;
      if (stb.nLoad)  nCur <= nLo;
      if (stb.nInc)   nCur <= nCur + WideW'(1);
      if (stb.plInc)  pl <= pl + PlW'(1);
      if (stb.take) begin
        bestM <= m[CoefW-1:0]; bestN <= nCur[CoefW-1:0]; bestPl <= pl; bestErr <= delta;
      end
    end
  end

  assign noMatch = (bestErr == '1);

  always_comb begin
    stat.divDone = divDone;
    stat.plOver  = pl > plHi;
    stat.mLast   = m == 9'(MMax);
    stat.ufLow   = uf < WideW'(CmpMinKhz);
    stat.ufHigh  = uf > WideW'(CmpMaxKhz);
    stat.nLoBig  = nLo > WideW'(NMax);
    stat.nPast   = nCur > nHi;
    stat.nSmall  = nCur < WideW'(NMin);
    stat.nBig    = nCur > WideW'(NMax);
    stat.vcoOk   = vco >= WideW'(VcoMinKhz) && vco <= maxVco;
    stat.better  = delta < bestErr;
    stat.exact   = delta == '0;
  end

  p_err_monotone_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.init |=> bestErr <= $past(bestErr));
  p_take_n_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |-> (nCur >= WideW'(NMin) && nCur <= WideW'(NMax)));
  p_take_cmp_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |-> (uf >= WideW'(CmpMinKhz) && uf <= WideW'(CmpMaxKhz)));
  p_take_pl_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |-> (pl <= plHi));
endmodule

// File: rtl/pll_search_ctrl.sv
module pll_search_ctrl
  import pll_search_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  dpStatT  stat,
  output ctrlStbT stb,
  output logic    done
);
  typedef enum logic [3:0] {
    SIdle, SBegin, SWait, SVt, SHi, SLo, SPlTop, SMTop, SUf, SN, SNTop,
    SVco, SLwv, SNextM, SNextPl, SFin
  } stateE;

  stateE state, stateNxt, after, afterNxt;

  always_comb begin
    stb = '0;
    stateNxt = state;
    afterNxt = after;
    case (state)
      SIdle:   if (start) begin stb.init = 1'b1; stateNxt = SBegin; end
      SBegin:  begin stb.divGo = 1'b1; stb.divOp = OpVt; afterNxt = SVt; stateNxt = SWait; end
      SWait:   if (stat.divDone) stateNxt = after;
      SVt:     begin stb.divGo = 1'b1; stb.divOp = OpHi; afterNxt = SHi; stateNxt = SWait; end
      SHi:     begin stb.divGo = 1'b1; stb.divOp = OpLo; afterNxt = SLo; stateNxt = SWait; end
      SLo:     stateNxt = SPlTop;
      SPlTop:  if (stat.plOver) stateNxt = SFin;
               else begin stb.mFirst = 1'b1; stateNxt = SMTop; end
      SMTop:   begin stb.divGo = 1'b1; stb.divOp = OpUf; afterNxt = SUf; stateNxt = SWait; end
      SUf:     if (stat.ufLow) stateNxt = SNextPl;
               else if (stat.ufHigh) stateNxt = SNextM;
               else begin stb.divGo = 1'b1; stb.divOp = OpN; afterNxt = SN; stateNxt = SWait; end
      SN:      if (stat.nLoBig) stateNxt = SNextPl;
               else begin stb.nLoad = 1'b1; stateNxt = SNTop; end
      SNTop:   if (stat.nPast) stateNxt = SNextM;
               else if (stat.nSmall) stb.nInc = 1'b1;
               else if (stat.nBig) stateNxt = SNextM;
               else begin stb.divGo = 1'b1; stb.divOp = OpVco; afterNxt = SVco; stateNxt = SWait; end
      SVco:    if (stat.vcoOk) begin
                 stb.divGo = 1'b1; stb.divOp = OpLwv; afterNxt = SLwv; stateNxt = SWait;
               end else begin stb.nInc = 1'b1; stateNxt = SNTop; end
      SLwv:    begin
                 if (stat.better) stb.take = 1'b1;
                 if (stat.better && stat.exact) stateNxt = SFin;
                 else begin stb.nInc = 1'b1; stateNxt = SNTop; end
               end
      SNextM:  if (stat.mLast) stateNxt = SNextPl;
               else begin stb.mInc = 1'b1; stateNxt = SMTop; end
      SNextPl: begin stb.plInc = 1'b1; stateNxt = SPlTop; end
      SFin:    stateNxt = SIdle;
      default: stateNxt = SIdle;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SIdle;
      after <= SIdle;
    end else begin
      state <= stateNxt;
      after <= afterNxt;
    end
  end

  assign done = (state == SFin);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10: a new search can only be entered from the idle state
  p_start_only_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state != SIdle) |=> (state != SBegin));
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
  import pll_search_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [FreqW-1:0] targetKhz,
  input  logic [FreqW-1:0] refKhz,
  output logic             done,
  output logic [CoefW-1:0] bestM,
  output logic [CoefW-1:0] bestN,
  output logic [PlW-1:0]   bestPl,
  output logic [WideW-1:0] bestErr,
  output logic             noMatch
);
  ctrlStbT stb;
  dpStatT  stat;

  pll_search_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat), .stb(stb), .done(done)
  );

  pll_search_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .targetKhz(targetKhz), .refKhz(refKhz),
    .stat(stat), .bestM(bestM), .bestN(bestN), .bestPl(bestPl), .bestErr(bestErr),
    .noMatch(noMatch)
  );

  p_nomatch_defaults_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && noMatch) |-> (bestM == CoefW'(MMax) && bestN == CoefW'(NMin)
                           && bestPl == PlW'(DefaultPl)));
endmodule

// File: tb/pll_coef_search_tb.sv
`timescale 1ns/1ps
module pll_coef_search_tb;
  import pll_search_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [FreqW-1:0] targetKhz = '0;
  logic [FreqW-1:0] refKhz = '0;
  logic done, noMatch;
  logic [CoefW-1:0] bestM, bestN;
  logic [PlW-1:0] bestPl;
  logic [WideW-1:0] bestErr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit prevDone = 1'b0;

  typedef struct {
    longint m, n, pl, err;
    bit nm;
    int job;
  } expT;
  expT sb[$];
  expT lastExp;

  always #4 clk = ~clk;

  pll_coef_search u_dut (
    .clk(clk), .rstN(rstN), .start(start), .targetKhz(targetKhz), .refKhz(refKhz),
    .done(done), .bestM(bestM), .bestN(bestN), .bestPl(bestPl), .bestErr(bestErr),
    .noMatch(noMatch)
  );

  // R2: ratio for each post-divider index
  function automatic longint ratioOf(input longint k);
    longint tab[15] = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32};
    if (k < 0 || k > 14) return 1;
    return tab[k];
  endfunction

  function automatic longint idxOf(input longint r);
    longint c = (r < 1) ? 1 : (r > 32) ? 32 : r;
    for (int k = 0; k < 14; k++) if (ratioOf(k) >= c) return k;
    return 14;
  endfunction

  function automatic expT model(input longint tg, input longint rf, input int job);
    expT e;
    longint t2, vt, mx, lo, hi, d, vtp, uf, n, n2, vco, lwv, dl;
    bit found = 1'b0;
    t2 = 2 * tg;
    vt = t2 + t2 / 50;
    mx = (vt > 2064000) ? vt : 2064000;
    hi = idxOf((mx + vt - 1) / vt);
    lo = idxOf(1000000 / vt);
    e.m = 255; e.n = 8; e.pl = 1; e.err = (longint'(1) << WideW) - 1; e.job = job;
    for (longint pl = lo; pl <= hi && !found; pl++) begin
      d = ratioOf(pl);
      vtp = t2 * d;
      for (longint m = 1; m <= 255 && !found; m++) begin
        uf = rf / m;
        if (uf < 12000) break;
        if (uf > 38000) continue;
        n = (vtp * m) / rf;
        n2 = (vtp * m + rf - 1) / rf;
        if (n > 255) break;
        for (; n <= n2 && !found; n++) begin
          if (n < 8) continue;
          if (n > 255) break;
          vco = rf * n / m;
          if (vco >= 1000000 && vco <= mx) begin
            lwv = (vco + d / 2) / d;
            dl = (lwv > t2) ? lwv - t2 : t2 - lwv;
            if (dl < e.err) begin
              e.err = dl; e.m = m; e.n = n; e.pl = pl;
              if (dl == 0) found = 1'b1;
            end
          end
        end
      end
    end
    e.nm = (e.err == (longint'(1) << WideW) - 1);
    return e;
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Driver: pushes the model's answer, then launches the search
  task automatic runJob(input longint tg, input longint rf, input int job, input bit poke);
    expT e;
    e = model(tg, rf, job);
    sb.push_back(e);
    lastExp = e;
    @(negedge clk);
    targetKhz = FreqW'(tg); refKhz = FreqW'(rf); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10: second start mid-search with different inputs
      repeat (30) @(negedge clk);
      targetKhz = FreqW'(5000); refKhz = FreqW'(19200); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (sb.size() == 0);
    repeat (6) @(negedge clk);
    // R9: results hold after done
    chk(bestM == CoefW'(e.m) && bestN == CoefW'(e.n) && bestPl == PlW'(e.pl),
        "R9 hold", longint'(bestM), e.m);
  endtask

  // Monitor: compares on every done cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone) chk(!done, "R9 done width", longint'(done), 0);
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R10 unexpected done", 1, 0);
        end else begin
          expT e;
          e = sb.pop_front();
          chk(bestM == CoefW'(e.m), $sformatf("R4 bestM job%0d", e.job), longint'(bestM), e.m);
          chk(bestN == CoefW'(e.n), $sformatf("R5 bestN job%0d", e.job), longint'(bestN), e.n);
          chk(bestPl == PlW'(e.pl), $sformatf("R3 bestPl job%0d", e.job), longint'(bestPl), e.pl);
          chk(longint'(bestErr) == e.err, $sformatf("R6 R7 bestErr job%0d", e.job),
              longint'(bestErr), e.err);
          chk(noMatch == e.nm, $sformatf("R8 noMatch job%0d", e.job), longint'(noMatch),
              longint'(e.nm));
        end
      end
      prevDone = done;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      chk(1'b0, "R9 watchdog", cycles, 190000);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!done, "R1 done", longint'(done), 0);
    chk(bestM == 8'd255 && bestN == 8'd8, "R1 M/N", longint'(bestM), 255);
    chk(bestPl == 4'd1 && noMatch, "R1 PL/noMatch", longint'(bestPl), 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    runJob(72000, 12000, 1, 1'b0);     // exact match stops early (R7)
    runJob(1100000, 38400, 2, 1'b0);   // ceiling set by the target (R3)
    runJob(1000, 38400, 3, 1'b0);      // every N below 8 (R5, R8)
    runJob(1600000, 12000, 4, 1'b0);   // floor of N above 255 (R5, R8)
    runJob(50000, 10000, 5, 1'b0);     // comparison frequency too low (R4, R8)
    runJob(396000, 38400, 6, 1'b1);    // extra start ignored (R10)
    runJob(852000, 19200, 7, 1'b0);
    runJob(540000, 27000, 8, 1'b0);
    runJob(250123, 38400, 9, 1'b0);    // inexact, error path (R6)
    runJob(333333, 19200, 10, 1'b0);
    runJob(612000, 50000, 11, 1'b0);   // M=1 skipped as too high (R4)
    runJob(700001, 13000, 12, 1'b0);
    repeat (20) @(negedge clk);
    chk(sb.size() == 0, "R10 scoreboard drained", sb.size(), 0);
    finishRun();
  end
endmodule